// File: doc/BRIEF.md
# Write Completion Status Logic

This block tells a host whether a self-timed write into a nonvolatile byte array is still in progress. A page controller supplies a busy flag and the byte it wrote last. The host's read strobes arrive as three active-low controls. Array read data comes from outside. The block builds the value placed on the host data bus, a flag that says when the bus is driven, and a pull-down request for a shared, wired ready/busy line.

While a write runs, every read returns a polling word in place of array data. The top bit is the inverse of the top bit of the byte last written. The next bit flips once per read. The remaining bits read as zero. Once the write ends, reads return array data unchanged. The host can therefore use any of three indications to find the end of the write: watch the top bit until it matches what was written, read twice and compare the toggle bit, or sample the wired ready line.

No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level control or status signal. The bus value and the bus-drive flag depend combinationally on the inputs. Only the read-edge detector and the toggle bit hold state.

Top module: `wr_status_top`

## Requirements
- R1: `bus_drive_o` is 1 exactly when `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1 (a read). Otherwise it is 0, which stands for high impedance.
- R2: During a read with `busy_i`=0, `bus_data_o` equals `arr_data_i`.
- R3: During a read with `busy_i`=1, `bus_data_o[7]` is the inverse of `last_byte_i[7]`.
- R4: During a read with `busy_i`=1, `bus_data_o[6]` is 1 on the first read started in the current write cycle and alternates on each later read. A read starts in the first clock cycle in which the read condition of R1 holds, after a cycle in which it did not.
- R5: A read held for many clock cycles counts as one read, so `bus_data_o[6]` stays constant for the whole of that read.
- R6: The toggle sequence restarts at each rise of `busy_i`. Reads started in an earlier write cycle have no effect on the bit 6 pattern of a new one.
- R7: During a read with `busy_i`=1, `bus_data_o[5:0]` reads as zero.
- R8: `rb_pull_o` is 1, pulling the wired line low, whenever `busy_i`=1. It is 0, releasing the line, whenever `busy_i`=0.
- R9: On the first read after `busy_i` falls, all bits are true array data and bit 6 no longer alternates.
- R10: After reset, with no read in progress, `bus_drive_o`=0. The first read of a write cycle that begins right after reset returns 1 on bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Self-timed write in progress |
| last_byte_i | input | 8 | Last byte written by the page controller |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| arr_data_i | input | 8 | Array read data |
| bus_data_o | output | 8 | Value presented on the host data bus |
| bus_drive_o | output | 1 | 1 when the bus is driven, 0 for high impedance |
| rb_pull_o | output | 1 | 1 pulls the shared ready/busy line low |

## Verification
The only state is the registered read strobe and the toggle bit. A fault in either shows on bit 6 of the first busy read that follows it. A missed or doubled read-edge detection makes bit 6 repeat or skip a value on the next read. A toggle bit that is not cleared at a write start appears as a 0 on the first poll of that write. Long held reads and back-to-back write cycles are what expose these faults. The bench therefore mixes random strobe lengths with directed reads that span many cycles and with two writes in quick succession.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;
  typedef enum logic [1:0] {
    BUS_OFF  = 2'd0,
    BUS_TRUE = 2'd1,
    BUS_POLL = 2'd2
  } bus_sel_e;
endpackage

// File: rtl/wr_status_strobe.sv
module wr_status_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  output logic rd_active_o,
  output logic rd_start_o
);
  logic rd_q;

  assign rd_active_o = !ce_n_i && !oe_n_i && we_n_i;
  assign rd_start_o  = rd_active_o && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_active_o;
  end

  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start_o |=> !rd_start_o); // R5
endmodule

// File: rtl/wr_status_toggle.sv
module wr_status_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rd_start_i,
  output logic tog_o
);
  logic busy_q;
  logic tog_q;
  logic busy_rise;
  logic tog_base;

  assign busy_rise = busy_i && !busy_q;
  assign tog_base  = busy_rise ? 1'b0 : tog_q;
  assign tog_o     = tog_base ^ (rd_start_i && busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (busy_i) tog_q <= tog_o;
    end
  end

  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_start_i && !busy_rise) |=> $stable(tog_q)); // R5
  AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rise && !rd_start_i) |=> (tog_q == 1'b0)); // R6
endmodule

// File: rtl/wr_status_mux.sv
module wr_status_mux
  import wr_status_pkg::*;
#(
  parameter int DW = 8
) (
  input  bus_sel_e      sel_i,
  input  logic [DW-1:0] arr_i,
  input  logic [DW-1:0] last_i,
  input  logic          tog_i,
  output logic [DW-1:0] data_o
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  always_comb begin
    data_o = '0;
    unique case (sel_i)
      BUS_TRUE: data_o = arr_i;
      BUS_POLL: begin
        data_o[POLL_BIT] = ~last_i[POLL_BIT];
        data_o[TOG_BIT]  = tog_i;
      end
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/wr_status_top.sv
module wr_status_top
  import wr_status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic [DW-1:0] last_byte_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_drive_o,
  output logic          rb_pull_o
);
  localparam int POLL_BIT = DW - 1;
  localparam int LOW_W    = DW - 2;

  logic     rd_active;
  logic     rd_start;
  logic     tog;
  bus_sel_e sel;

  wr_status_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
    .rd_active_o(rd_active), .rd_start_o(rd_start)
  );

  wr_status_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .rd_start_i(rd_start), .tog_o(tog)
  );

  always_comb begin
    if (!rd_active)  sel = BUS_OFF;
    else if (busy_i) sel = BUS_POLL;
    else             sel = BUS_TRUE;
  end

  wr_status_mux #(.DW(DW)) u_mux (
    .sel_i(sel), .arr_i(arr_data_i), .last_i(last_byte_i), .tog_i(tog), .data_o(bus_data_o)
  );

  assign bus_drive_o = rd_active;
  assign rb_pull_o   = busy_i;

  AST_HIZ_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i || oe_n_i || !we_n_i) |-> !bus_drive_o); // R1
  AST_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive_o && !busy_i) |-> (bus_data_o == arr_data_i)); // R2
  AST_POLL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive_o && busy_i) |-> (bus_data_o[POLL_BIT] != last_byte_i[POLL_BIT])); // R3
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive_o && busy_i) |-> (bus_data_o[LOW_W-1:0] == '0)); // R7
  AST_TOG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive_o && busy_i && $past(bus_drive_o) && $past(busy_i))
      |-> $stable(bus_data_o[DW-2])); // R5
endmodule

// File: tb/wr_status_top_tb_top.sv
module wr_status_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic [7:0] last_b = 8'h00;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] arr = 8'h00;
  logic [7:0] bus_data;
  logic       bus_drive, rb_pull;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  bit busy_prev = 1'b0;
  bit rd_prev   = 1'b0;
  int rd_cnt    = 0;
  int idle_since = 100;

  always #4 clk = ~clk;

  wr_status_top dut_i (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .last_byte_i(last_b),
    .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n), .arr_data_i(arr),
    .bus_data_o(bus_data), .bus_drive_o(bus_drive), .rb_pull_o(rb_pull)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_read(input logic c, input logic o, input logic w);
    return !c && !o && w;
  endfunction

  // expected bit 6: parity of reads started in the current write cycle
  function automatic bit exp_tog(input int cnt);
    return cnt[0];
  endfunction

  // drive at negedge, check after settle, then advance model at posedge
  task automatic step(input bit b, input logic [7:0] lb, input logic c, input logic o,
                      input logic w, input logic [7:0] a);
    bit rd, rs;
    @(negedge clk);
    busy = b; last_b = lb; ce_n = c; oe_n = o; we_n = w; arr = a;
    #1;
    rd = is_read(c, o, w);
    rs = rd && !rd_prev;
    if (b && !busy_prev) rd_cnt = 0;
    if (b && rs) rd_cnt++;
    chk("R1 bus_drive", {7'b0, bus_drive}, {7'b0, rd});
    chk("R8 rb_pull", {7'b0, rb_pull}, {7'b0, b});
    if (rd && !b) begin
      if (idle_since < 3) chk("R9 true data after write", bus_data, a);
      else                chk("R2 idle read", bus_data, a);
    end
    if (rd && b) begin
      chk("R3 poll top bit", {7'b0, bus_data[7]}, {7'b0, ~lb[7]});
      chk("R4 toggle bit", {7'b0, bus_data[6]}, {7'b0, exp_tog(rd_cnt)});
      chk("R7 low bits", {2'b0, bus_data[5:0]}, 8'h00);
    end
    @(posedge clk);
    idle_since = b ? 0 : idle_since + 1;
    busy_prev = b;
    rd_prev = rd;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit b;
    logic [7:0] lb;
    logic c, o, w;
    int seed_v;
    bit first6;
    seed_v = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset bus off", {7'b0, bus_drive}, 8'h00);
    chk("R10 reset rb released", {7'b0, rb_pull}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: first read of a write right after reset gives bit 6 = 1
    step(1, 8'h80, 1, 1, 1, 8'h11);
    step(1, 8'h80, 0, 0, 1, 8'h11);
    chk("R10 first poll bit6", {7'b0, bus_data[6]}, 8'h01);

    // R5: one long read keeps bit 6 fixed
    step(1, 8'h80, 1, 1, 1, 8'h00);
    step(1, 8'h80, 0, 0, 1, 8'h00);
    first6 = bus_data[6];
    for (int i = 0; i < 10; i++) step(1, 8'h80, 0, 0, 1, 8'h00);
    chk("R5 long read bit6 stable", {7'b0, bus_data[6]}, {7'b0, first6});

    // R1: write cycle (WE low) keeps the bus undriven
    step(1, 8'h80, 0, 0, 0, 8'h00);
    chk("R1 WE low no drive", {7'b0, bus_drive}, 8'h00);

    // R9: end of write, then read true data
    step(0, 8'h80, 1, 1, 1, 8'hC3);
    step(0, 8'h80, 0, 0, 1, 8'hC3);
    chk("R9 data after done", bus_data, 8'hC3);

    // R6: new write after an odd number of polls restarts at 1
    step(1, 8'h3C, 1, 1, 1, 8'h00);
    step(1, 8'h3C, 0, 0, 1, 8'h00);
    step(1, 8'h3C, 1, 1, 1, 8'h00);
    step(0, 8'h3C, 1, 1, 1, 8'h00);
    step(1, 8'h3C, 1, 1, 1, 8'h00);
    step(1, 8'h3C, 0, 0, 1, 8'h00);
    chk("R6 restart bit6", {7'b0, bus_data[6]}, 8'h01);
    step(1, 8'h3C, 1, 1, 1, 8'h00);

    // constrained random
    b = 0; lb = 8'h00; c = 1; o = 1; w = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        b = ~b;
        if (b) lb = 8'($urandom);
      end
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 2) != 0) begin c = 0; o = 0; w = 1; end
        else begin c = 1'($urandom); o = 1'($urandom); w = 1'($urandom); end
      end
      step(b, lb, c, o, w, 8'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule